// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Address-Space Tags

This block is a small, fully associative translation buffer for a processor's memory-management unit. Every slot describes two neighbouring 4 KB virtual pages, an even one and an odd one, that share a single virtual tag. Each of the two pages has its own physical frame number and its own valid, dirty and cacheable flags. A slot also carries an address-space identifier, so that mappings of different processes can sit in the buffer side by side.

Software fills a slot through an indexed write port. In normal use, the write-random path supplies the index from the replacement counter, which keeps clear of the low slots reserved for the operating system. A separate lookup port is purely combinational. It takes a virtual address and the current address-space identifier, and in the same cycle it returns the physical address, a hit indication and the three flags of the selected page.

A match on a page whose valid flag is clear is still reported as a hit. The caller can then tell an invalid page apart from an absent mapping.

Top module: `pair_tlb`

## Requirements
- R1: After reset every slot holds a zero tag, zero identifier, zero frames and cleared flags. Until the first write, no lookup reports valid. A lookup of addresses 0x0000_0000 to 0x0000_1FFF with identifier 0 reports a hit with valid 0.
- R2: A lookup hits only when virtual address bits 31:13 equal the slot's stored page-pair tag and the lookup identifier equals the slot's stored identifier. A mismatch in either field gives no hit from that slot.
- R3: Virtual address bit 12 picks the page within the pair: 0 selects the even frame and flags, 1 selects the odd frame and flags. Each flags field is 3 bits wide, with bit 2 = valid, bit 1 = dirty and bit 0 = cacheable.
- R4: On a hit, the physical address is the selected 20-bit frame number in bits 31:12, followed by virtual address bits 11:0.
- R5: A hit on a page whose valid bit is 0 reports hit=1 and valid=0. The dirty and cacheable outputs still show the stored bits and the physical address is still formed.
- R6: On a miss, hit, valid, dirty, cacheable and the physical address are all zero.
- R7: A write changes the slot from the next clock edge onward. A lookup in the same cycle as the write sees the slot's old contents.
- R8: A write whose index is 48 or more changes no slot.
- R9: When more than one slot matches, the slot with the lowest index supplies the result.
- R10: A write replaces the whole slot, so the slot's previous tag no longer hits through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Slot index to write |
| wr_vpn2 | input | 19 | Page-pair tag (virtual address bits 31:13) |
| wr_asid | input | 8 | Address-space identifier stored with the slot |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_flags_even | input | 3 | Even page flags {valid, dirty, cacheable} |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_flags_odd | input | 3 | Odd page flags {valid, dirty, cacheable} |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_pa | output | 32 | Translated physical address |
| lk_hit | output | 1 | A slot matched |
| lk_valid | output | 1 | Selected page is valid |
| lk_dirty | output | 1 | Selected page is dirty |
| lk_cache | output | 1 | Selected page is cacheable |

## Verification
A slot whose stored tag, identifier, frame or flags is corrupted shows at the lookup outputs in the same cycle that the address is presented. This happens because the lookup path has no register between the stored state and the ports. A write that lands a cycle early or late, or in the wrong slot, shows up on the first lookup of that page pair after the write. The reference model checks these outputs on every cycle. A wrong choice between slots that match at once only shows while two slots share a tag and identifier, so the bench creates that situation on purpose and then removes it.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
    // Per-page attribute bits; packed order gives valid in bit 2.
    typedef struct packed {
        logic valid;
        logic dirty;
        logic cache;
    } pg_flags_t;
endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6,
    parameter int VPN2_W  = 19,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  pg_flags_t         wr_flags_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  pg_flags_t         wr_flags_odd,
    output logic [VPN2_W-1:0] tag_vpn  [ENTRIES],
    output logic [ASID_W-1:0] tag_asid [ENTRIES],
    output logic [PFN_W-1:0]  pfn_even [ENTRIES],
    output logic [PFN_W-1:0]  pfn_odd  [ENTRIES],
    output pg_flags_t         fl_even  [ENTRIES],
    output pg_flags_t         fl_odd   [ENTRIES]
);
    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn_e;
        logic [PFN_W-1:0]  pfn_o;
        pg_flags_t         fl_e;
        pg_flags_t         fl_o;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } state_t;

    state_t state_d, state_q;
    logic   idx_ok;

    assign idx_ok = (int'(wr_idx) < ENTRIES);

    always_comb begin
        state_d = state_q;
        if (wr_en && idx_ok) begin
            state_d.slot[wr_idx].vpn2  = wr_vpn2;
            state_d.slot[wr_idx].asid  = wr_asid;
            state_d.slot[wr_idx].pfn_e = wr_pfn_even;
            state_d.slot[wr_idx].pfn_o = wr_pfn_odd;
            state_d.slot[wr_idx].fl_e  = wr_flags_even;
            state_d.slot[wr_idx].fl_o  = wr_flags_odd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tag_vpn[i]  = state_q.slot[i].vpn2;
            tag_asid[i] = state_q.slot[i].asid;
            pfn_even[i] = state_q.slot[i].pfn_e;
            pfn_odd[i]  = state_q.slot[i].pfn_o;
            fl_even[i]  = state_q.slot[i].fl_e;
            fl_odd[i]   = state_q.slot[i].fl_o;
        end
    end
endmodule

// File: rtl/pair_tlb_match.sv
module pair_tlb_match #(
    parameter int ENTRIES = 48,
    parameter int VPN2_W  = 19,
    parameter int ASID_W  = 8
) (
    input  logic [VPN2_W-1:0] lk_vpn2,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN2_W-1:0] tag_vpn  [ENTRIES],
    input  logic [ASID_W-1:0] tag_asid [ENTRIES],
    output logic [ENTRIES-1:0] match_vec
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match_vec[e] = (tag_vpn[e] == lk_vpn2) && (tag_asid[e] == lk_asid);
    end
endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic [ENTRIES-1:0] match_vec,
    input  logic               odd_sel,
    input  logic [OFF_W-1:0]   va_off,
    input  logic [PFN_W-1:0]   pfn_even [ENTRIES],
    input  logic [PFN_W-1:0]   pfn_odd  [ENTRIES],
    input  pg_flags_t          fl_even  [ENTRIES],
    input  pg_flags_t          fl_odd   [ENTRIES],
    output logic [PFN_W+OFF_W-1:0] pa,
    output logic               hit,
    output pg_flags_t          flags
);
    logic [PFN_W-1:0] sel_pfn;

    // Scan from the top down so the lowest matching index is assigned last.
    always_comb begin
        hit     = 1'b0;
        sel_pfn = '0;
        flags   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                sel_pfn = odd_sel ? pfn_odd[i] : pfn_even[i];
                flags   = odd_sel ? fl_odd[i]  : fl_even[i];
            end
        end
    end

    assign pa = hit ? {sel_pfn, va_off} : '0;
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int ASID_W  = 8,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VPN2_W = VA_W - OFF_W - 1,
    localparam int PFN_W  = PA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic [2:0]        wr_flags_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic [2:0]        wr_flags_odd,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_hit,
    output logic              lk_valid,
    output logic              lk_dirty,
    output logic              lk_cache
);
    logic [VPN2_W-1:0]  tag_vpn  [ENTRIES];
    logic [ASID_W-1:0]  tag_asid [ENTRIES];
    logic [PFN_W-1:0]   pfn_even [ENTRIES];
    logic [PFN_W-1:0]   pfn_odd  [ENTRIES];
    pg_flags_t          fl_even  [ENTRIES];
    pg_flags_t          fl_odd   [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    pg_flags_t          sel_flags;

    pair_tlb_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN2_W(VPN2_W),
        .ASID_W(ASID_W), .PFN_W(PFN_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_vpn2      (wr_vpn2),
        .wr_asid      (wr_asid),
        .wr_pfn_even  (wr_pfn_even),
        .wr_flags_even(pg_flags_t'(wr_flags_even)),
        .wr_pfn_odd   (wr_pfn_odd),
        .wr_flags_odd (pg_flags_t'(wr_flags_odd)),
        .tag_vpn      (tag_vpn),
        .tag_asid     (tag_asid),
        .pfn_even     (pfn_even),
        .pfn_odd      (pfn_odd),
        .fl_even      (fl_even),
        .fl_odd       (fl_odd)
    );

    pair_tlb_match #(
        .ENTRIES(ENTRIES), .VPN2_W(VPN2_W), .ASID_W(ASID_W)
    ) u_match (
        .lk_vpn2  (lk_va[VA_W-1:OFF_W+1]),
        .lk_asid  (lk_asid),
        .tag_vpn  (tag_vpn),
        .tag_asid (tag_asid),
        .match_vec(match_vec)
    );

    pair_tlb_pick #(
        .ENTRIES(ENTRIES), .PFN_W(PFN_W), .OFF_W(OFF_W)
    ) u_pick (
        .match_vec(match_vec),
        .odd_sel  (lk_va[OFF_W]),
        .va_off   (lk_va[OFF_W-1:0]),
        .pfn_even (pfn_even),
        .pfn_odd  (pfn_odd),
        .fl_even  (fl_even),
        .fl_odd   (fl_odd),
        .pa       (lk_pa),
        .hit      (lk_hit),
        .flags    (sel_flags)
    );

    assign lk_valid = sel_flags.valid;
    assign lk_dirty = sel_flags.dirty;
    assign lk_cache = sel_flags.cache;
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int ASID_W = 8,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 6,
    parameter int VPN2_W = 19,
    parameter int PFN_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [VPN2_W-1:0] wr_vpn2,
    input logic [ASID_W-1:0] wr_asid,
    input logic [PFN_W-1:0]  wr_pfn_even,
    input logic [PFN_W-1:0]  wr_pfn_odd,
    input logic [VA_W-1:0]   lk_va,
    input logic [ASID_W-1:0] lk_asid,
    input logic [PA_W-1:0]   lk_pa,
    input logic              lk_hit,
    input logic              lk_valid,
    input logic              lk_dirty,
    input logic              lk_cache
);
    logic armed_q;
    logic wrote_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (wr_en) wrote_q <= 1'b1;
        end
    end

    AST_RESET_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !wrote_q |-> !lk_valid); // R1

    AST_MISS_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_valid && !lk_dirty && !lk_cache && lk_pa == '0)); // R6

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0])); // R4

    AST_SLOT0_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wr_en && wr_idx == '0)
         && lk_va[VA_W-1:OFF_W+1] == $past(wr_vpn2) && lk_asid == $past(wr_asid))
        |-> (lk_hit && lk_pa[PA_W-1:OFF_W] ==
             (lk_va[OFF_W] ? $past(wr_pfn_odd) : $past(wr_pfn_even)))); // R7
endmodule

bind pair_tlb pair_tlb_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .VPN2_W(VPN2_W), .PFN_W(PFN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_pfn_even(wr_pfn_even),
    .wr_pfn_odd(wr_pfn_odd), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_pa(lk_pa), .lk_hit(lk_hit), .lk_valid(lk_valid),
    .lk_dirty(lk_dirty), .lk_cache(lk_cache)
);

// File: tb/pair_tlb_tb.sv
module pair_tlb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic [19:0] wr_pfn_even = '0;
    logic [2:0]  wr_flags_even = '0;
    logic [19:0] wr_pfn_odd = '0;
    logic [2:0]  wr_flags_odd = '0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic [31:0] lk_pa;
    logic        lk_hit, lk_valid, lk_dirty, lk_cache;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model contents
    logic [18:0] m_vpn [N];
    logic [7:0]  m_asid[N];
    logic [19:0] m_pe  [N];
    logic [19:0] m_po  [N];
    logic [2:0]  m_fe  [N];
    logic [2:0]  m_fo  [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_pfn_even(wr_pfn_even),
        .wr_flags_even(wr_flags_even), .wr_pfn_odd(wr_pfn_odd),
        .wr_flags_odd(wr_flags_odd), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_pa(lk_pa), .lk_hit(lk_hit), .lk_valid(lk_valid),
        .lk_dirty(lk_dirty), .lk_cache(lk_cache)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_pe[i] = '0;
            m_po[i] = '0; m_fe[i] = '0; m_fo[i] = '0;
        end
    endtask

    // Compare outputs against the model (pre-write state), then apply the write.
    task automatic tick(input string tag);
        logic [35:0] exp_v, act_v;
        int found;
        #1;
        found = -1;
        for (int i = 0; i < N; i++) begin
            if (found < 0 && m_vpn[i] == lk_va[31:13] && m_asid[i] == lk_asid) found = i;
        end
        if (found < 0) begin
            exp_v = '0;
        end else if (lk_va[12]) begin
            exp_v = {1'b1, m_fo[found], m_po[found], lk_va[11:0]};
        end else begin
            exp_v = {1'b1, m_fe[found], m_pe[found], lk_va[11:0]};
        end
        act_v = {lk_hit, lk_valid, lk_dirty, lk_cache, lk_pa};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s va=%h asid=%h actual=%h expected=%h",
                     tag, lk_va, lk_asid, act_v, exp_v);
        end
        if (wr_en && wr_idx < N) begin
            m_vpn[wr_idx] = wr_vpn2; m_asid[wr_idx] = wr_asid;
            m_pe[wr_idx] = wr_pfn_even; m_po[wr_idx] = wr_pfn_odd;
            m_fe[wr_idx] = wr_flags_even; m_fo[wr_idx] = wr_flags_odd;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input string tag);
        lk_va = va; lk_asid = asid;
        tick(tag);
    endtask

    task automatic put(input int idx, input logic [31:0] va, input logic [7:0] asid,
                       input logic [19:0] pe, input logic [2:0] fe,
                       input logic [19:0] po, input logic [2:0] fo);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn2 = va[31:13]; wr_asid = asid;
        wr_pfn_even = pe; wr_flags_even = fe; wr_pfn_odd = po; wr_flags_odd = fo;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared state, zero tag hits as invalid
        look(32'h0000_0000, 8'h00, "R1");
        look(32'h0000_1ABC, 8'h00, "R1");
        look(32'h1234_5678, 8'h03, "R1");

        // R7: same-cycle lookup sees old content
        put(5, 32'h7FFF_E000, 8'h05, 20'h00000, 3'b000, 20'h01CC4, 3'b011);
        look(32'h7FFF_F123, 8'h05, "R7");
        // R5: invalid page reported as hit with stored dirty/cacheable
        look(32'h7FFF_F123, 8'h05, "R5");
        look(32'h7FFF_E456, 8'h05, "R5");

        // R3 / R4: even and odd selection and address formation
        put(6, 32'h0040_0000, 8'h01, 20'h00AAA, 3'b101, 20'h00BBB, 3'b110);
        look(32'h0040_0ABC, 8'h01, "R7");
        look(32'h0040_0ABC, 8'h01, "R3");
        look(32'h0040_1DEF, 8'h01, "R4");

        // R2 / R6: identifier and tag mismatches miss
        look(32'h0040_0ABC, 8'h02, "R2");
        look(32'h0040_2000, 8'h01, "R6");

        // R8: out-of-range indices write nothing
        put(48, 32'h0080_0000, 8'h01, 20'h11111, 3'b111, 20'h22222, 3'b111);
        look(32'h0080_0000, 8'h01, "R8");
        put(63, 32'h0080_0000, 8'h01, 20'h11111, 3'b111, 20'h22222, 3'b111);
        look(32'h0080_1000, 8'h01, "R8");
        look(32'h0080_1000, 8'h01, "R8");

        // R9: duplicate mapping, lowest index wins
        put(2, 32'h0040_0000, 8'h01, 20'hCCCCC, 3'b111, 20'hDDDDD, 3'b100);
        look(32'h0040_0010, 8'h01, "R9");
        look(32'h0040_0010, 8'h01, "R9");
        look(32'h0040_1010, 8'h01, "R9");

        // R10: overwrite slot 2, slot 6 shows again
        put(2, 32'h0900_0000, 8'h07, 20'h0F0F0, 3'b100, 20'h0E0E0, 3'b001);
        look(32'h0040_0010, 8'h01, "R10");
        look(32'h0040_0010, 8'h01, "R10");
        look(32'h0900_1FFF, 8'h07, "R10");

        // Top slot boundary
        put(47, 32'h0AAA_0000, 8'hFF, 20'h47470, 3'b110, 20'h74740, 3'b101);
        look(32'h0AAA_1234, 8'hFF, "R7");
        look(32'h0AAA_1234, 8'hFF, "R2");

        // Mixed traffic over a small tag set
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) begin
                put(int'(r[6:1]) % 56, {3'd0, r[9:8], 14'd0, r[10], 12'd0},
                    {7'd0, r[11]}, 20'($urandom), 3'($urandom),
                    20'($urandom), 3'($urandom));
            end
            lk_va = {3'd0, r[13:12], 14'd0, r[15:14], r[27:16]};
            lk_asid = {7'd0, r[28]};
            tick("R2");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule